// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flag

This block is a 64-entry, 18-bit first-in first-out buffer. A producer writes on its load clock and a consumer reads on a separate unload clock, and the two clocks may run at unrelated rates. Pointers cross between the domains as Gray codes through two-flop synchronizers. Full, half-full and a combined threshold flag are produced in the load domain. Empty is produced in the unload domain. The oldest word is always presented on the read data output (first-word fall-through), so `rd_en` acknowledges the word that is already shown. The read data output floats when the output enable is high.

After reset, while `prog_n` is low, the first one or two enabled load edges do not store data. They capture the two offsets of the threshold flag from the low six bits of `wr_data`. The first edge sets the low-water offset, and the second sets the high-water offset. The threshold flag is high when the buffer is nearly empty or nearly full, and a consumer can use it to pace transfers.

Both domains reset synchronously while `rst_n` is low. `rst_n` must be held low for at least three edges of each clock.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released with nothing written, the flags are `full_n`=1, `empty_n`=0, `half_full`=0 and `almost_flag`=1.
- R2: `full_n` goes low on the load edge that stores the 64th unread word. A write attempted while `full_n` is low stores nothing, and the 64 stored words read back unchanged.
- R3: A read strobe (`rd_en`=1) applied while `empty_n` is low is ignored. `empty_n` stays low, and the next word written is still the next word read.
- R4: A word written into an empty buffer appears on `rd_data` without a read strobe. `empty_n` rises at the third unload edge after the load edge that wrote the word.
- R5: Once both domains have settled, `half_full` is 1 at 32 or more held words and 0 at 31 or fewer.
- R6: Once settled, `almost_flag` is 1 when the held count is at most L or at least 64-H, and 0 for counts from L+1 to 63-H.
- R7: With `prog_n` low after reset, the first enabled load edge loads L from `wr_data[5:0]` and the second loads H from `wr_data[5:0]`. Neither of these edges stores a word.
- R8: If `prog_n` is high at the first enabled load edge after reset, L=H=8. If `prog_n` rises after exactly one programming edge, H equals L.
- R9: Words leave in the order they were written, with their values intact, across the two clock domains.
- R10: While `oe_n` is high, `rd_data` is high-impedance. While `oe_n` is low, `rd_data` shows the head word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Load clock |
| rd_clk | input | 1 | Unload clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| prog_n | input | 1 | Active-low enable for loading the offsets |
| wr_en | input | 1 | Load strobe, sampled on `wr_clk` |
| wr_data | input | 18 | Word to store, or offset value while programming |
| rd_en | input | 1 | Unload strobe that acknowledges the head word, sampled on `rd_clk` |
| oe_n | input | 1 | Active-low output enable for `rd_data` |
| rd_data | output | 18 | Head word, or high-impedance |
| full_n | output | 1 | Low when 64 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 32 or more words |
| almost_flag | output | 1 | High when nearly empty or nearly full |

## Verification
`full_n` is a registered load-domain result, so the bench samples it at the falling load edge right after the write that fills the buffer. `empty_n` passes through two synchronizer stages and the prefetch register, so it is sampled after exactly the second and third unload edges that follow the write. Half-full and the threshold flag track the far domain only after up to three local edges plus one remote edge. For these two flags the bench first waits six edges of each clock and only then compares them against its own count.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DATA_W_DEF = 18;
  localparam int unsigned ADDR_W_DEF = 6;
  localparam int unsigned OFFS_DEF   = 8;

  typedef enum logic [1:0] {
    PG_LOW  = 2'd0,
    PG_HIGH = 2'd1,
    PG_DONE = 2'd2
  } prog_stage_e;
endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 18
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out[W-1] = sync_q[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W_DEF,
  parameter int unsigned OFFS = OFFS_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          prog_n,
  input  logic [AW-1:0] prog_val,
  input  logic [AW:0]   rd_bin,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW:0]   wr_gray,
  output logic          full_n,
  output logic          half_full,
  output logic          almost_flag
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = DEPTH / 2;

  prog_stage_e   stage_q, stage_nxt;
  logic [AW-1:0] low_q, low_nxt, high_q, high_nxt;
  logic [PW-1:0] wr_ptr, wr_ptr_nxt, cnt_nxt, high_lim;
  logic          full_q, hf_q, af_q;
  logic          prog_edge, push;

  assign prog_edge = wr_en && !prog_n && (stage_q != PG_DONE);
  assign push      = wr_en && !prog_edge && !full_q;

  always_comb begin
    stage_nxt = stage_q;
    low_nxt   = low_q;
    high_nxt  = high_q;
    if (prog_edge) begin
      if (stage_q == PG_LOW) begin
        low_nxt   = prog_val;
        high_nxt  = prog_val;
        stage_nxt = PG_HIGH;
      end else begin
        high_nxt  = prog_val;
        stage_nxt = PG_DONE;
      end
    end else if (wr_en) begin
      stage_nxt = PG_DONE;
    end
  end

  assign wr_ptr_nxt = wr_ptr + PW'(push);
  assign cnt_nxt    = wr_ptr_nxt - rd_bin;
  assign high_lim   = PW'(DEPTH) - {1'b0, high_nxt};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= PG_LOW;
      low_q   <= AW'(OFFS);
      high_q  <= AW'(OFFS);
      wr_ptr  <= '0;
      wr_gray <= '0;
      full_q  <= 1'b0;
      hf_q    <= 1'b0;
      af_q    <= 1'b1;
    end else begin
      stage_q <= stage_nxt;
      low_q   <= low_nxt;
      high_q  <= high_nxt;
      wr_ptr  <= wr_ptr_nxt;
      wr_gray <= wr_ptr_nxt ^ (wr_ptr_nxt >> 1);
      full_q  <= (cnt_nxt == PW'(DEPTH));
      hf_q    <= (cnt_nxt >= PW'(HALF));
      af_q    <= (cnt_nxt <= {1'b0, low_nxt}) || (cnt_nxt >= high_lim);
    end
  end

  assign ram_we      = push;
  assign ram_waddr   = wr_ptr[AW-1:0];
  assign full_n      = !full_q;
  assign half_full   = hf_q;
  assign almost_flag = af_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_bin) <= PW'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (full_q && wr_en && !prog_edge) |=> $stable(wr_ptr)); // R2
  AST_PROG_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    prog_edge |=> $stable(wr_ptr)); // R7
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> half_full); // R5
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned AW = ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wr_bin,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [AW:0]   rd_gray,
  output logic          empty_n
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] fetch_ptr, ack_ptr, ack_nxt;
  logic          head_vld;
  logic          has_data, fetch, consume;

  assign has_data = (fetch_ptr != wr_bin);
  assign fetch    = has_data && (!head_vld || rd_en);
  assign consume  = rd_en && head_vld;
  assign ack_nxt  = ack_ptr + PW'(consume);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_ptr <= '0;
      ack_ptr   <= '0;
      rd_gray   <= '0;
      head_vld  <= 1'b0;
    end else begin
      fetch_ptr <= fetch_ptr + PW'(fetch);
      ack_ptr   <= ack_nxt;
      rd_gray   <= ack_nxt ^ (ack_nxt >> 1);
      head_vld  <= fetch || (head_vld && !rd_en);
    end
  end

  assign ram_re    = fetch;
  assign ram_raddr = fetch_ptr[AW-1:0];
  assign empty_n   = head_vld;

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (!head_vld && rd_en) |=> $stable(ack_ptr)); // R3
  AST_HEAD_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_ptr - ack_ptr) == PW'(head_vld)); // R4
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DW   = DATA_W_DEF,
  parameter int unsigned AW   = ADDR_W_DEF,
  parameter int unsigned OFFS = OFFS_DEF
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          prog_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost_flag
);
  localparam int unsigned PW = AW + 1;

  logic          rst;
  logic          ram_we, ram_re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_gray, rd_gray, wr_bin_rd, rd_bin_wr;
  logic [DW-1:0] head_word;

  assign rst = !rst_n;

  dcf_wr_ctrl #(.AW(AW), .OFFS(OFFS)) u_wr (
    .clk(wr_clk), .rst(rst), .wr_en(wr_en), .prog_n(prog_n),
    .prog_val(wr_data[AW-1:0]), .rd_bin(rd_bin_wr),
    .ram_we(ram_we), .ram_waddr(waddr), .wr_gray(wr_gray),
    .full_n(full_n), .half_full(half_full), .almost_flag(almost_flag)
  );

  dcf_gray_sync #(.W(PW)) u_sync_to_rd (
    .clk(rd_clk), .rst(rst), .gray_in(wr_gray), .bin_out(wr_bin_rd)
  );

  dcf_gray_sync #(.W(PW)) u_sync_to_wr (
    .clk(wr_clk), .rst(rst), .gray_in(rd_gray), .bin_out(rd_bin_wr)
  );

  dcf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_en(rd_en), .wr_bin(wr_bin_rd),
    .ram_re(ram_re), .ram_raddr(raddr), .rd_gray(rd_gray),
    .empty_n(empty_n)
  );

  dcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wr_clk(wr_clk), .we(ram_we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .re(ram_re), .raddr(raddr), .rdata(head_word)
  );

  assign rd_data = oe_n ? {DW{1'bz}} : head_word;
endmodule

// File: tb/dual_clock_flag_fifo_bench.sv
module dual_clock_flag_fifo_bench;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        rst_n = 1'b0, prog_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0, oe_n = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        full_n, empty_n, half_full, almost_flag;

  int checks = 0, errors = 0;
  logic [17:0] mq [128];
  int head = 0, cnt = 0;
  logic [17:0] wseq = 18'h00100;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dual_clock_flag_fifo u_dual_clock_flag_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prog_n(prog_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .oe_n(oe_n),
    .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .almost_flag(almost_flag)
  );

  // {writes[7:0], reads[7:0], half_full, almost_flag, full_n, empty_n}
  // offsets L=H=8 (R8 default)
  localparam logic [19:0] VEC [13] = '{
    {8'd8,  8'd0,  4'b0111}, {8'd1,  8'd0,  4'b0011},
    {8'd22, 8'd0,  4'b0011}, {8'd1,  8'd0,  4'b1011},
    {8'd23, 8'd0,  4'b1011}, {8'd1,  8'd0,  4'b1111},
    {8'd8,  8'd0,  4'b1101}, {8'd2,  8'd0,  4'b1101},
    {8'd0,  8'd1,  4'b1111}, {8'd0,  8'd32, 4'b0011},
    {8'd0,  8'd22, 4'b0011}, {8'd0,  8'd1,  4'b0111},
    {8'd0,  8'd8,  4'b0110}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pg);
    rst_n = 1'b0; prog_n = pg; wr_en = 1'b0; rd_en = 1'b0;
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    rst_n = 1'b1;
    head = 0; cnt = 0;
  endtask

  task automatic wr1(input logic [17:0] d, input bit is_data);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
    if (is_data && cnt < 64) begin
      mq[(head + cnt) % 128] = d;
      cnt++;
    end
  endtask

  task automatic wr_data_n(input int n);
    for (int i = 0; i < n; i++) begin
      wr1(wseq, 1'b1);
      wseq = wseq + 18'd1;
    end
  endtask

  task automatic rd1(input string req);
    @(negedge rd_clk);
    if (cnt > 0) begin
      chk(rd_data == mq[head], req, rd_data, mq[head]);
      head = (head + 1) % 128;
      cnt--;
    end
    rd_en = 1'b1;
    @(posedge rd_clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b1);
    @(negedge wr_clk);
    chk(full_n == 1 && empty_n == 0 && half_full == 0 && almost_flag == 1, "R1",
        {full_n, empty_n, half_full, almost_flag}, 4'b1001);

    // R3 reads while empty are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk); rd_en = 1'b1;
      @(posedge rd_clk); #1 rd_en = 1'b0;
    end
    settle();
    chk(empty_n == 0, "R3", empty_n, 0);

    // R4 fall-through timing: rises at third unload edge after the write
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = 18'h2A5A5;
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
    mq[head] = 18'h2A5A5; cnt = 1;
    @(posedge rd_clk); @(posedge rd_clk); @(negedge rd_clk);
    chk(empty_n == 0, "R4", empty_n, 0);
    @(posedge rd_clk); @(negedge rd_clk);
    chk(empty_n == 1, "R4", empty_n, 1);
    chk(rd_data == 18'h2A5A5, "R4 R3", rd_data, 18'h2A5A5);

    // R10 output enable
    oe_n = 1'b1; #1;
    chk($isunknown(rd_data) || rd_data != 18'h2A5A5, "R10", rd_data, 18'h3FFFF);
    oe_n = 1'b0; #1;
    chk(rd_data == 18'h2A5A5, "R10", rd_data, 18'h2A5A5);
    rd1("R9");
    settle();
    chk(empty_n == 0, "R3", empty_n, 0);

    // Table walk: R2 R5 R6 R8 R9 with default offsets
    do_reset(1'b1);
    for (int v = 0; v < 13; v++) begin
      wr_data_n(int'(VEC[v][19:12]));
      for (int r = 0; r < int'(VEC[v][11:4]); r++) rd1("R9");
      settle();
      chk(half_full == VEC[v][3], "R5", half_full, VEC[v][3]);
      chk(almost_flag == VEC[v][2], "R6 R8", almost_flag, VEC[v][2]);
      chk(full_n == VEC[v][1], "R2", full_n, VEC[v][1]);
      chk(empty_n == VEC[v][0], "R3 R4", empty_n, VEC[v][0]);
    end

    // R2 full_n falls on the 64th write edge
    do_reset(1'b1);
    wr_data_n(63);
    settle();
    chk(full_n == 1, "R2", full_n, 1);
    wr_data_n(1);
    @(negedge wr_clk);
    chk(full_n == 0, "R2", full_n, 0);

    // R7 two programming edges: L=3, H=10
    do_reset(1'b0);
    wr1(18'h3FFC3, 1'b0);
    wr1(18'h0000A, 1'b0);
    prog_n = 1'b1;
    wr_data_n(3); settle();
    chk(almost_flag == 1, "R7", almost_flag, 1);
    wr_data_n(1); settle();
    chk(almost_flag == 0, "R7", almost_flag, 0);
    wr_data_n(49); settle();
    chk(almost_flag == 0, "R7", almost_flag, 0);
    wr_data_n(1); settle();
    chk(almost_flag == 1, "R7", almost_flag, 1);
    rd1("R7");

    // R8 single programming edge: L=H=5
    do_reset(1'b0);
    wr1(18'h00005, 1'b0);
    prog_n = 1'b1;
    wr_data_n(5); settle();
    chk(almost_flag == 1, "R8", almost_flag, 1);
    wr_data_n(1); settle();
    chk(almost_flag == 0, "R8", almost_flag, 0);
    wr_data_n(52); settle();
    chk(almost_flag == 0, "R8", almost_flag, 0);
    wr_data_n(1); settle();
    chk(almost_flag == 1, "R8", almost_flag, 1);
    rd1("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule